// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Sequencer

This block sits beside the controller of a DRAM that keeps its most recently read row in an on-chip row cache. It watches the controller's row-enable cycles and sorts each one into a class. A cycle can be a counter refresh started by the refresh strobe, a column-before-row refresh, a read, a write, a self-refresh entry, or an illegal cycle. The block keeps the internal refresh row counter and issues a one-cycle refresh strobe with the row to refresh. It also tells the controller when a read must load a new row into the cache.

All control inputs are sampled levels with the asserted meaning active high. Row-enable activity arrives as single-cycle fall and rise events. A start-up tracker raises a sticky ready flag once the required quiet time and mix of cycles have been seen. Timing rules are counted in clock cycles, and a broken rule sets a sticky rule-error flag. After ready, a watchdog counts refresh strobes in fixed windows and flags refresh starvation.

Top module: `rfseq_top`

## Requirements
- R1: After reset, rfsh_stb, cache_load, ready, in_selfref, err_rule and err_starve are 0, and the refresh row counter is 0.
- R2: A fall event with rf_act=1 is a counter refresh, whether or not cl_act is also set. One cycle after the event, rfsh_stb is 1 for one cycle with rfsh_row equal to the counter, zero-extended. The counter advances by one when that cycle's rise event arrives.
- R3: The counter is CNT_W=10 bits wide and wraps from 1023 to 0. Bit 10 of rfsh_row is 0 on every counter refresh.
- R4: A write cycle is a fall with cs_act=1, wr_sel=1 and rf_act=0. If it ends with no cl_act in any of its cycles, rfsh_stb pulses one cycle after the rise event with rfsh_row equal to the row given at the fall. It does not load the cache and leaves the last-read row unchanged. If cl_act was seen, no strobe is issued.
- R5: A read cycle is a fall with cs_act=1, wr_sel=0 and rf_act=0. It never strobes refresh. If the row differs from the last-read row, or none has been read since reset, cache_load pulses one cycle after the fall and the row becomes the last-read row. A matching row produces no pulse.
- R6: A fall with cs_act=0, wr_sel=1, rf_act=0, we_act=0 and cl_act=1 enters self-refresh. in_selfref is 1 from one cycle after the fall until the rise event. While in self-refresh, a counter refresh strobe is issued every SR_PERIOD cycles, the first at SR_PERIOD cycles after entry.
- R7: Once self-refresh ends, any fall seen fewer than SR_PRE idle cycles after the rise sets err_rule.
- R8: A fall seen before row enable has been idle for INIT_HIGH cycles since reset sets err_rule.
- R9: A fall with cs_act=0 that is neither a counter refresh nor a self-refresh entry sets err_rule and starts no cycle.
- R10: ready rises only when the quiet time of R8 has passed, at least INIT_CYC=10 cycles have completed, at least INIT_FCYC=8 of them were counter refreshes, and at least INIT_RDS=2 reads loaded the cache. ready is then sticky.
- R11: After ready, if fewer than WD_MIN refresh strobes occur in a window of WD_WIN cycles, err_starve is set.
- R12: err_rule and err_starve stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_fall | input | 1 | One-cycle event: row enable became active |
| row_rise | input | 1 | One-cycle event: row enable became inactive |
| cs_act | input | 1 | Chip select asserted |
| wr_sel | input | 1 | 1 selects write, 0 selects read |
| rf_act | input | 1 | Refresh strobe asserted |
| cl_act | input | 1 | Column latch asserted |
| we_act | input | 1 | Write enable asserted |
| row_addr | input | ROW_W | Row address presented at the fall event |
| rfsh_row | output | ROW_W | Row being refreshed |
| rfsh_stb | output | 1 | One-cycle refresh strobe |
| cache_load | output | 1 | One-cycle pulse: read row must be loaded into the cache |
| ready | output | 1 | Start-up complete |
| in_selfref | output | 1 | Self-refresh in progress |
| err_rule | output | 1 | Sticky timing or protocol rule violation |
| err_starve | output | 1 | Sticky refresh starvation |

## Verification
Every result is registered, so each is due a fixed number of edges after its event. A counter refresh strobe and a cache-load pulse appear one edge after the fall. A row-enable-only strobe appears one edge after the rise. The self-refresh strobes fall on multiples of SR_PERIOD edges after entry. ready appears two edges after the rise that completes its last condition. The bench drives each event at a falling clock edge and samples at the very next falling edge, so it reads each result in the one cycle it is due. Strobe counts and wrap values come from a counter model kept in the bench.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNT,
        ST_RD,
        ST_WR,
        ST_SELF
    } seq_st_e;

    typedef enum logic [2:0] {
        CY_CNT,
        CY_READ,
        CY_WRITE,
        CY_SELF,
        CY_BAD
    } cyc_kind_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rf;
        logic cl;
        logic we;
    } ctl_lv_t;

    // Class of a cycle from the control levels present at its start.
    function automatic cyc_kind_e decode_kind(ctl_lv_t c);
        if (c.rf)                            return CY_CNT;
        if (!c.sel && c.wr && c.cl && !c.we) return CY_SELF;
        if (!c.sel)                          return CY_BAD;
        if (c.wr)                            return CY_WRITE;
        return CY_READ;
    endfunction

endpackage

// File: rtl/rfseq_decode.sv
module rfseq_decode
    import rfseq_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  ctl_lv_t          lv,
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] last_row,
    input  logic             last_ok,
    output cyc_kind_e        kind,
    output logic             rd_hit
);
    always_comb begin
        kind   = decode_kind(lv);
        rd_hit = last_ok && (row == last_row);
    end
endmodule

// File: rtl/rfseq_rowctr.sv
module rfseq_rowctr #(
    parameter int CNT_W     = 10,
    parameter int SR_PERIOD = 7812
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             self_on,
    output logic [CNT_W-1:0] cnt,
    output logic             self_tick
);
    localparam int TW = (SR_PERIOD > 2) ? $clog2(SR_PERIOD) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(SR_PERIOD - 1);

    logic [TW-1:0] tmr;

    assign self_tick = self_on && (tmr == T_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tmr <= '0;
        end else begin
            if (adv || self_tick) cnt <= cnt + 1'b1;
            if (!self_on || self_tick) tmr <= '0;
            else                       tmr <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/rfseq_init.sv
module rfseq_init #(
    parameter int INIT_CYC  = 10,
    parameter int INIT_FCYC = 8,
    parameter int INIT_RDS  = 2,
    parameter int WD_WIN    = 8000000,
    parameter int WD_MIN    = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic quiet_ok,
    input  logic cyc_done,
    input  logic f_done,
    input  logic rd_miss,
    input  logic stb,
    output logic ready,
    output logic starve
);
    localparam int CW = $clog2(INIT_CYC + 1);
    localparam int FW = $clog2(INIT_FCYC + 1);
    localparam int RW = $clog2(INIT_RDS + 1);
    localparam int WW = $clog2(WD_WIN);
    localparam int MW = $clog2(WD_MIN + 1);
    localparam logic [CW-1:0] CYC_C  = CW'(INIT_CYC);
    localparam logic [FW-1:0] F_C    = FW'(INIT_FCYC);
    localparam logic [RW-1:0] RD_C   = RW'(INIT_RDS);
    localparam logic [WW-1:0] W_LAST = WW'(WD_WIN - 1);
    localparam logic [MW-1:0] MIN_C  = MW'(WD_MIN);
    localparam logic [MW-1:0] MIN_M1 = MW'(WD_MIN - 1);

    logic [CW-1:0] cyc_n;
    logic [FW-1:0] f_n;
    logic [RW-1:0] rd_n;
    logic [WW-1:0] wd_t;
    logic [MW-1:0] rf_n;
    logic          win_end;
    logic          enough;

    always_comb begin
        win_end = ready && (wd_t == W_LAST);
        enough  = (rf_n == MIN_C) || (stb && (rf_n == MIN_M1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_n  <= '0;
            f_n    <= '0;
            rd_n   <= '0;
            ready  <= 1'b0;
            wd_t   <= '0;
            rf_n   <= '0;
            starve <= 1'b0;
        end else begin
            if (quiet_ok) begin
                if (cyc_done && cyc_n != CYC_C) cyc_n <= cyc_n + 1'b1;
                if (f_done   && f_n   != F_C)   f_n   <= f_n + 1'b1;
                if (rd_miss  && rd_n  != RD_C)  rd_n  <= rd_n + 1'b1;
            end
            if (quiet_ok && cyc_n == CYC_C && f_n == F_C && rd_n == RD_C)
                ready <= 1'b1;
            if (ready) begin
                if (win_end) begin
                    wd_t <= '0;
                    rf_n <= '0;
                    if (!enough) starve <= 1'b1;
                end else begin
                    wd_t <= wd_t + 1'b1;
                    if (stb && rf_n != MIN_C) rf_n <= rf_n + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rfseq_top.sv
module rfseq_top
    import rfseq_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int CNT_W     = 10,
    parameter int INIT_HIGH = 38,
    parameter int SR_PRE    = 13,
    parameter int SR_PERIOD = 7812,
    parameter int INIT_CYC  = 10,
    parameter int INIT_FCYC = 8,
    parameter int INIT_RDS  = 2,
    parameter int WD_WIN    = 8000000,
    parameter int WD_MIN    = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_fall,
    input  logic             row_rise,
    input  logic             cs_act,
    input  logic             wr_sel,
    input  logic             rf_act,
    input  logic             cl_act,
    input  logic             we_act,
    input  logic [ROW_W-1:0] row_addr,
    output logic [ROW_W-1:0] rfsh_row,
    output logic             rfsh_stb,
    output logic             cache_load,
    output logic             ready,
    output logic             in_selfref,
    output logic             err_rule,
    output logic             err_starve
);
    localparam int HMAX = (INIT_HIGH > SR_PRE) ? INIT_HIGH : SR_PRE;
    localparam int HW   = $clog2(HMAX + 1);
    localparam logic [HW-1:0] HMAX_C = HW'(HMAX);
    localparam logic [HW-1:0] INIT_C = HW'(INIT_HIGH);
    localparam logic [HW-1:0] PRE_C  = HW'(SR_PRE);

    seq_st_e          st;
    ctl_lv_t          lv;
    cyc_kind_e        kind;
    logic             rd_hit;
    logic [ROW_W-1:0] last_row;
    logic             last_ok;
    logic [ROW_W-1:0] row_q;
    logic             col_seen;
    logic [HW-1:0]    hi_cnt;
    logic             quiet_ok;
    logic             sr_guard;
    logic [CNT_W-1:0] cnt;
    logic             self_tick;
    logic             st_idle;
    logic             fall_ok;
    logic             rise_ok;
    logic             f_end;
    logic             re_only;
    logic             rd_miss;
    logic             cnt_start;
    logic             early;
    logic             stb_d;

    assign lv = '{sel: cs_act, wr: wr_sel, rf: rf_act, cl: cl_act, we: we_act};

    rfseq_decode #(.ROW_W(ROW_W)) u_dec (
        .lv       (lv),
        .row      (row_addr),
        .last_row (last_row),
        .last_ok  (last_ok),
        .kind     (kind),
        .rd_hit   (rd_hit)
    );

    rfseq_rowctr #(.CNT_W(CNT_W), .SR_PERIOD(SR_PERIOD)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .adv       (f_end),
        .self_on   (st == ST_SELF),
        .cnt       (cnt),
        .self_tick (self_tick)
    );

    rfseq_init #(
        .INIT_CYC (INIT_CYC),
        .INIT_FCYC(INIT_FCYC),
        .INIT_RDS (INIT_RDS),
        .WD_WIN   (WD_WIN),
        .WD_MIN   (WD_MIN)
    ) u_init (
        .clk      (clk),
        .rst      (rst),
        .quiet_ok (quiet_ok),
        .cyc_done (rise_ok),
        .f_done   (f_end),
        .rd_miss  (rd_miss),
        .stb      (rfsh_stb),
        .ready    (ready),
        .starve   (err_starve)
    );

    always_comb begin
        st_idle   = (st == ST_IDLE);
        fall_ok   = row_fall && st_idle;
        rise_ok   = row_rise && !st_idle;
        f_end     = rise_ok && (st == ST_CNT);
        re_only   = rise_ok && (st == ST_WR) && !(col_seen || cl_act);
        rd_miss   = fall_ok && (kind == CY_READ) && !rd_hit;
        cnt_start = fall_ok && (kind == CY_CNT);
        early     = fall_ok && ((!quiet_ok && hi_cnt < INIT_C) ||
                                (sr_guard && hi_cnt < PRE_C));
        stb_d     = cnt_start || re_only || self_tick;
    end

    assign in_selfref = (st == ST_SELF);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            last_row   <= '0;
            last_ok    <= 1'b0;
            row_q      <= '0;
            col_seen   <= 1'b0;
            hi_cnt     <= '0;
            quiet_ok   <= 1'b0;
            sr_guard   <= 1'b0;
            rfsh_row   <= '0;
            rfsh_stb   <= 1'b0;
            cache_load <= 1'b0;
            err_rule   <= 1'b0;
        end else begin
            // cycle class and return to idle
            if (fall_ok) begin
                unique case (kind)
                    CY_CNT:   st <= ST_CNT;
                    CY_READ:  st <= ST_RD;
                    CY_WRITE: st <= ST_WR;
                    CY_SELF:  st <= ST_SELF;
                    default:  st <= ST_IDLE;
                endcase
                row_q    <= row_addr;
                col_seen <= 1'b0;
                sr_guard <= 1'b0;
            end else if (rise_ok) begin
                st <= ST_IDLE;
                if (st == ST_SELF) sr_guard <= 1'b1;
            end else if (st == ST_WR && cl_act) begin
                col_seen <= 1'b1;
            end

            // idle-time counter
            if (rise_ok)                             hi_cnt <= '0;
            else if (st_idle && !fall_ok && hi_cnt != HMAX_C) hi_cnt <= hi_cnt + 1'b1;
            if (st_idle && hi_cnt >= INIT_C)         quiet_ok <= 1'b1;

            // last-read row tracking
            if (rd_miss) begin
                last_row <= row_addr;
                last_ok  <= 1'b1;
            end

            // outputs
            rfsh_stb   <= stb_d;
            cache_load <= rd_miss;
            if (re_only)                     rfsh_row <= row_q;
            else if (cnt_start || self_tick) rfsh_row <= ROW_W'(cnt);

            if (early || (fall_ok && kind == CY_BAD)) err_rule <= 1'b1;
        end
    end
endmodule

// File: rtl/rfseq_chk.sv
module rfseq_chk #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             row_fall,
    input logic             row_rise,
    input logic             cs_act,
    input logic             wr_sel,
    input logic             rf_act,
    input logic             cl_act,
    input logic             we_act,
    input logic             st_idle,
    input logic [ROW_W-1:0] rfsh_row,
    input logic             rfsh_stb,
    input logic             cache_load,
    input logic             ready,
    input logic             in_selfref,
    input logic             err_rule,
    input logic             err_starve
);
    assert_cnt_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (row_fall && rf_act && st_idle) |=> rfsh_stb);

    assert_cnt_row_top_R3: assert property (@(posedge clk) disable iff (rst)
        (row_fall && rf_act && st_idle) |=> !rfsh_row[ROW_W-1]);

    assert_load_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
        cache_load |-> $past(row_fall));

    assert_load_no_stb_R5: assert property (@(posedge clk) disable iff (rst)
        !(cache_load && rfsh_stb));

    assert_self_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (row_fall && st_idle && !cs_act && wr_sel && !rf_act && cl_act && !we_act)
        |=> in_selfref);

    assert_self_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (in_selfref && row_rise) |=> !in_selfref);

    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (err_rule || err_starve) |=> (err_rule || err_starve));
endmodule

bind rfseq_top rfseq_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .row_fall   (row_fall),
    .row_rise   (row_rise),
    .cs_act     (cs_act),
    .wr_sel     (wr_sel),
    .rf_act     (rf_act),
    .cl_act     (cl_act),
    .we_act     (we_act),
    .st_idle    (st_idle),
    .rfsh_row   (rfsh_row),
    .rfsh_stb   (rfsh_stb),
    .cache_load (cache_load),
    .ready      (ready),
    .in_selfref (in_selfref),
    .err_rule   (err_rule),
    .err_starve (err_starve)
);

// File: tb/sim_rfseq_top.sv
module sim_rfseq_top;
    localparam int ROW_W = 11;
    localparam int INIT_HIGH = 8;
    localparam int SR_PRE = 4;
    localparam int SR_PERIOD = 5;
    localparam int WD_WIN = 60;
    localparam int WD_MIN = 2;

    localparam int OP_F = 0, OP_CBR = 1, OP_RD = 2, OP_WRN = 3, OP_WRC = 4,
                   OP_SELF = 5, OP_BAD = 6;

    // {op[2:0], row[10:0], strobe at fall, cache load, strobe at rise}
    localparam logic [16:0] VEC [10] = '{
        {3'(OP_F),   11'h000, 1'b1, 1'b0, 1'b0},
        {3'(OP_CBR), 11'h000, 1'b1, 1'b0, 1'b0},
        {3'(OP_RD),  11'h123, 1'b0, 1'b0, 1'b0},
        {3'(OP_RD),  11'h456, 1'b0, 1'b1, 1'b0},
        {3'(OP_WRN), 11'h7FF, 1'b0, 1'b0, 1'b1},
        {3'(OP_RD),  11'h456, 1'b0, 1'b0, 1'b0},
        {3'(OP_WRC), 11'h456, 1'b0, 1'b0, 1'b0},
        {3'(OP_WRN), 11'h010, 1'b0, 1'b0, 1'b1},
        {3'(OP_RD),  11'h010, 1'b0, 1'b1, 1'b0},
        {3'(OP_F),   11'h000, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_fall = 1'b0, row_rise = 1'b0;
    logic cs_act = 1'b0, wr_sel = 1'b0, rf_act = 1'b0, cl_act = 1'b0, we_act = 1'b0;
    logic [ROW_W-1:0] row_addr = '0;
    logic [ROW_W-1:0] rfsh_row;
    logic rfsh_stb, cache_load, ready, in_selfref, err_rule, err_starve;

    int tests = 0;
    int fails = 0;
    int stb_seen = 0;
    int bcnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rfseq_top #(
        .INIT_HIGH(INIT_HIGH), .SR_PRE(SR_PRE), .SR_PERIOD(SR_PERIOD),
        .WD_WIN(WD_WIN), .WD_MIN(WD_MIN)
    ) u0 (
        .clk(clk), .rst(rst), .row_fall(row_fall), .row_rise(row_rise),
        .cs_act(cs_act), .wr_sel(wr_sel), .rf_act(rf_act), .cl_act(cl_act),
        .we_act(we_act), .row_addr(row_addr), .rfsh_row(rfsh_row),
        .rfsh_stb(rfsh_stb), .cache_load(cache_load), .ready(ready),
        .in_selfref(in_selfref), .err_rule(err_rule), .err_starve(err_starve)
    );

    always @(negedge clk) if (!rst && rfsh_stb) stb_seen++;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic set_lv(input int op);
        cs_act = 1'b1; wr_sel = 1'b0; rf_act = 1'b0; cl_act = 1'b0; we_act = 1'b0;
        case (op)
            OP_F:    rf_act = 1'b1;
            OP_CBR:  begin rf_act = 1'b1; cl_act = 1'b1; end
            OP_WRN, OP_WRC: wr_sel = 1'b1;
            OP_SELF: begin cs_act = 1'b0; wr_sel = 1'b1; cl_act = 1'b1; end
            OP_BAD:  cs_act = 1'b0;
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; row_fall = 1'b0; row_rise = 1'b0; set_lv(OP_RD); cs_act = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bcnt = 0;
    endtask

    task automatic quiet();
        repeat (INIT_HIGH + 3) @(negedge clk);
    endtask

    task automatic run_cycle(input int op, input logic [ROW_W-1:0] row,
                             output logic fs, output logic [ROW_W-1:0] fr,
                             output logic ld, output logic rs,
                             output logic [ROW_W-1:0] rr);
        set_lv(op);
        row_addr = row;
        row_fall = 1'b1;
        @(negedge clk);
        row_fall = 1'b0;
        fs = rfsh_stb; fr = rfsh_row; ld = cache_load;
        rf_act = 1'b0;
        cl_act = (op == OP_WRC);
        @(negedge clk);
        cl_act = 1'b0;
        @(negedge clk);
        row_rise = 1'b1;
        @(negedge clk);
        row_rise = 1'b0;
        rs = rfsh_stb; rr = rfsh_row;
        @(negedge clk);
        if (op == OP_F || op == OP_CBR) bcnt = (bcnt + 1) % 1024;
    endtask

    task automatic do_init();
        logic fs, ld, rs;
        logic [ROW_W-1:0] fr, rr;
        for (int i = 0; i < 8; i++) run_cycle(OP_F, '0, fs, fr, ld, rs, rr);
        run_cycle(OP_RD, 11'h005, fs, fr, ld, rs, rr);
        run_cycle(OP_RD, 11'h123, fs, fr, ld, rs, rr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic fs, ld, rs;
        logic [ROW_W-1:0] fr, rr;
        int s0;

        // R1 reset state
        do_reset();
        @(negedge clk);
        chk("R1 stb", rfsh_stb, 0);
        chk("R1 load", cache_load, 0);
        chk("R1 ready", ready, 0);
        chk("R1 selfref", in_selfref, 0);
        chk("R1 err", {err_rule, err_starve}, 0);
        quiet();

        // R10 start-up mix
        for (int i = 0; i < 8; i++) begin
            run_cycle(OP_F, '0, fs, fr, ld, rs, rr);
            if (i == 0) chk("R1 counter starts at 0", fr, 0);
        end
        run_cycle(OP_RD, 11'h005, fs, fr, ld, rs, rr);
        chk("R10 not ready after 9 cycles", ready, 0);
        run_cycle(OP_RD, 11'h005, fs, fr, ld, rs, rr);
        chk("R5 hit gives no load", ld, 0);
        chk("R10 not ready with one distinct read", ready, 0);
        run_cycle(OP_RD, 11'h123, fs, fr, ld, rs, rr);
        chk("R5 miss loads", ld, 1);
        chk("R10 ready", ready, 1);
        chk("R8 no error on legal start", err_rule, 0);

        // vector table: R2 R4 R5
        foreach (VEC[i]) begin
            int op;
            logic [ROW_W-1:0] row, exp_row;
            op = int'(VEC[i][16:14]);
            row = VEC[i][13:3];
            exp_row = (op == OP_F || op == OP_CBR) ? ROW_W'(bcnt) : row;
            run_cycle(op, row, fs, fr, ld, rs, rr);
            chk("R2 strobe at fall", fs, VEC[i][2]);
            chk("R5 cache load", ld, VEC[i][1]);
            chk("R4 strobe at rise", rs, VEC[i][0]);
            if (VEC[i][2]) chk("R2 counter row", fr, exp_row);
            if (VEC[i][0]) chk("R4 external row", rr, exp_row);
        end

        // R6 self-refresh
        set_lv(OP_SELF);
        row_fall = 1'b1;
        @(negedge clk);
        row_fall = 1'b0;
        set_lv(OP_RD);
        chk("R6 in self-refresh", in_selfref, 1);
        s0 = stb_seen;
        repeat (15) @(negedge clk);
        row_rise = 1'b1;
        @(negedge clk);
        row_rise = 1'b0;
        chk("R6 exit", in_selfref, 0);
        chk("R6 strobe count", stb_seen - s0, 3);
        bcnt = bcnt + 3;
        repeat (SR_PRE + 2) @(negedge clk);
        run_cycle(OP_F, '0, fs, fr, ld, rs, rr);
        chk("R6 counter advanced by self-refresh", fr, 11'(bcnt - 1));
        chk("R7 no error after full precharge", err_rule, 0);

        // R7 early fall after self-refresh
        set_lv(OP_SELF);
        row_fall = 1'b1;
        @(negedge clk);
        row_fall = 1'b0;
        set_lv(OP_RD);
        repeat (2) @(negedge clk);
        row_rise = 1'b1;
        @(negedge clk);
        row_rise = 1'b0;
        run_cycle(OP_F, '0, fs, fr, ld, rs, rr);
        chk("R7 early fall flagged", err_rule, 1);
        repeat (5) @(negedge clk);
        chk("R12 rule error sticky", err_rule, 1);

        // R8 fall before quiet time
        do_reset();
        @(negedge clk);
        run_cycle(OP_F, '0, fs, fr, ld, rs, rr);
        chk("R8 early start flagged", err_rule, 1);

        // R9 unselected non-refresh cycle
        do_reset();
        quiet();
        run_cycle(OP_BAD, 11'h00A, fs, fr, ld, rs, rr);
        chk("R9 illegal cycle flagged", err_rule, 1);
        chk("R9 no strobe", {fs, rs, ld}, 0);

        // R3 wrap and R11 watchdog
        do_reset();
        quiet();
        do_init();
        while (bcnt != 1023) run_cycle(OP_F, '0, fs, fr, ld, rs, rr);
        run_cycle(OP_F, '0, fs, fr, ld, rs, rr);
        chk("R3 last row", fr, 11'd1023);
        run_cycle(OP_CBR, '0, fs, fr, ld, rs, rr);
        chk("R3 wrap to 0", fr, 0);
        chk("R11 fed watchdog quiet", err_starve, 0);
        repeat (3 * WD_WIN) @(negedge clk);
        chk("R11 starvation flagged", err_starve, 1);
        chk("R12 starve sticky", err_starve, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule